// File: doc/BRIEF.md
# LDPC Model Matrix Shift Scaler

This block produces the base matrix of a quasi-cyclic LDPC code for a chosen code length and rate. The model matrices are stored once, with circulant shift values defined for the longest code (n = 2304, expansion factor 96). At run time the block derives the expansion factor z = n / 24 from the requested length. It then walks the selected model matrix and rescales every positive shift to fit the smaller circulant size.

A one-cycle start pulse captures the length and the rate code. The block then streams one matrix entry per clock in row-major order. Each entry carries its row and column index, and the done flag marks the final entry. An unsupported request produces a single-cycle error pulse and no entries. The stored tables are stub patterns that are computed from a fixed formula. They stand in for the real tables of the standard.

Top module: `ldpc_shift_scaler`

## Requirements
- R1: While rst_ni is low, and after its release until the first start, entry_valid_o, done_o and error_o are low.
- R2: A length is accepted when it is a multiple of 24 in the range 576 to 2304, and z = length / 24. Rate codes 0..4 select 1/2, 2/3A, 2/3B, 3/4A and 3/4B.
- R3: A start with an unaccepted length or a rate code of 5..7 raises error_o for exactly one cycle, in the cycle after the start edge. No entry is emitted.
- R4: Each matrix has 24 columns. Rate codes 0/1/2/3/4 have 12/8/8/6/6 rows. Entries are emitted one per cycle without gaps, column index fastest (row-major).
- R5: The first entry (row 0, column 0) appears in the second cycle after the clock edge that samples start_i. In the first cycle after that edge, entry_valid_o is still low.
- R6: done_o is high exactly with the last entry (last row, column 23). In the cycle after it, entry_valid_o is low.
- R7: A stored entry of -1 (8'hFF, zero block) or 0 (identity) is output unchanged on the 8-bit two's-complement entry_shift_o.
- R8: For rate codes 0, 2, 3 and 4, a positive stored entry p is output as floor(p*z/96).
- R9: For rate code 1 (2/3A), a positive stored entry p is output as p mod z.
- R10: A start pulse that arrives while a matrix is being streamed is ignored. The running matrix completes with its original length, rate and entry count.
- R11: The stub table entry for rate code r, row i and column j is defined as follows. Let h = (7i + 13j + 5r) mod 17. The entry is -1 if h < 6 and 0 if h = 6. Otherwise it is ((11i + 29j + 3r) mod 95) + 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to generate a base matrix |
| len_i | input | 12 | Code length n, sampled with start_i |
| rate_i | input | 3 | Rate code 0..4, sampled with start_i |
| entry_valid_o | output | 1 | An entry is present on the outputs this cycle |
| entry_row_o | output | 4 | Row index of the entry |
| entry_col_o | output | 5 | Column index of the entry |
| entry_shift_o | output | 8 | Scaled shift, two's complement, -1 for a zero block |
| done_o | output | 1 | High with the final entry of the matrix |
| error_o | output | 1 | One-cycle pulse for an unsupported request |

## Verification
The bench targets the following corner cases, and each one catches a specific fault:
- **Rule choice.** Rate 2/3A is exercised at two lengths, so a design that applied floor scaling to it, or modulo to the other rates, gives wrong shift values.
- **Length bounds.** The length limits 576 and 2304 are tested, along with a length just outside each limit and one that is not a multiple of 24. A loose or off-by-one range check either emits a matrix it should reject or raises error_o on a legal request.
- **Pass-through values.** The bench watches -1 and 0 entries. A design that scaled them would emit 0 for a zero block.
- **Stream boundaries.** A start is injected mid-stream. A design that accepted it would restart or change z. The cycles right after the start and after done are also checked, which exposes an off-by-one in latency or a missing final entry.

// File: rtl/ldpc_scaler_pkg.sv
package ldpc_scaler_pkg;
  localparam int NCOLS     = 24;
  localparam int Z0        = 96;
  localparam int LEN_MIN   = 576;
  localparam int LEN_MAX   = 2304;
  localparam int NRATES    = 5;
  localparam int LEN_W     = 12;
  localparam int RATE_W    = 3;
  localparam int ROW_W     = 4;
  localparam int COL_W     = 5;
  localparam int SHIFT_W   = 8;
  localparam int Z_W       = 7;

  typedef enum logic {RULE_FLOOR = 1'b0, RULE_MOD = 1'b1} rule_e;

  localparam logic [RATE_W-1:0] RATE_MOD_CODE = 3'd1;

  // Stub table: stands in for the real model matrices
  function automatic logic [SHIFT_W-1:0] stub_entry(input int r, input int i, input int j);
    int h;
    int p;
    h = (7 * i + 13 * j + 5 * r) % 17;
    p = ((11 * i + 29 * j + 3 * r) % 95) + 1;
    if (h < 6)       stub_entry = '1;
    else if (h == 6) stub_entry = '0;
    else             stub_entry = SHIFT_W'(p);
  endfunction
endpackage

// File: rtl/ldpc_scaler_cfg.sv
module ldpc_scaler_cfg
  import ldpc_scaler_pkg::*;
#(
  parameter int P_LEN_W   = LEN_W,
  parameter int P_RATE_W  = RATE_W,
  parameter int P_ROW_W   = ROW_W,
  parameter int P_Z_W     = Z_W,
  parameter int P_NCOLS   = NCOLS,
  parameter int P_LEN_MIN = LEN_MIN,
  parameter int P_LEN_MAX = LEN_MAX,
  parameter int P_NRATES  = NRATES
) (
  input  logic [P_LEN_W-1:0]  len_i,
  input  logic [P_RATE_W-1:0] rate_i,
  output logic                ok_o,
  output logic [P_Z_W-1:0]    z_o,
  output rule_e               rule_o,
  output logic [P_ROW_W-1:0]  rows_o
);
  localparam logic [P_LEN_W-1:0] DIV   = P_LEN_W'(P_NCOLS);
  localparam logic [P_LEN_W-1:0] LMIN  = P_LEN_W'(P_LEN_MIN);
  localparam logic [P_LEN_W-1:0] LMAX  = P_LEN_W'(P_LEN_MAX);
  localparam logic [P_RATE_W-1:0] RMAX = P_RATE_W'(P_NRATES);

  logic [P_LEN_W-1:0] quot;
  logic [P_LEN_W-1:0] rem;
  logic               len_ok;
  logic               rate_ok;

  assign quot    = len_i / DIV;
  assign rem     = len_i % DIV;
  assign len_ok  = (len_i >= LMIN) && (len_i <= LMAX) && (rem == '0);
  assign rate_ok = rate_i < RMAX;
  assign ok_o    = len_ok && rate_ok;
  assign z_o     = P_Z_W'(quot);
  assign rule_o  = (rate_i == RATE_MOD_CODE) ? RULE_MOD : RULE_FLOOR;

  always_comb begin
    case (rate_i)
      3'd0:        rows_o = P_ROW_W'(12);
      3'd1, 3'd2:  rows_o = P_ROW_W'(8);
      default:     rows_o = P_ROW_W'(6);
    endcase
  end
endmodule

// File: rtl/ldpc_model_rom.sv
module ldpc_model_rom
  import ldpc_scaler_pkg::*;
#(
  parameter int P_RATE_W  = RATE_W,
  parameter int P_ROW_W   = ROW_W,
  parameter int P_COL_W   = COL_W,
  parameter int P_SHIFT_W = SHIFT_W
) (
  input  logic [P_RATE_W-1:0]  rate_i,
  input  logic [P_ROW_W-1:0]   row_i,
  input  logic [P_COL_W-1:0]   col_i,
  output logic [P_SHIFT_W-1:0] entry_o
);
  logic [SHIFT_W-1:0] raw;

  always_comb begin
    raw     = stub_entry(int'(rate_i), int'(row_i), int'(col_i));
    entry_o = P_SHIFT_W'(raw);
  end
endmodule

// File: rtl/ldpc_shift_scale.sv
module ldpc_shift_scale
  import ldpc_scaler_pkg::*;
#(
  parameter int P_SHIFT_W = SHIFT_W,
  parameter int P_Z_W     = Z_W,
  parameter int P_Z0      = Z0,
  parameter int P_Z_MIN   = LEN_MIN / NCOLS
) (
  input  logic [P_SHIFT_W-1:0] entry_i,
  input  logic [P_Z_W-1:0]     z_i,
  input  rule_e                rule_i,
  output logic [P_SHIFT_W-1:0] shift_o
);
  localparam int PW        = P_SHIFT_W + P_Z_W;
  // positive entries stay below z0, so quotient by z_min is bounded
  localparam int MOD_STEPS = (P_Z0 - 1) / P_Z_MIN;

  logic [PW-1:0]        prod;
  logic [PW-1:0]        quo;
  logic [P_SHIFT_W-1:0] zx;
  logic [P_SHIFT_W-1:0] floor_val;
  logic [P_SHIFT_W-1:0] mod_chain [MOD_STEPS+1];
  logic                 pass;

  assign prod      = PW'(entry_i) * PW'(z_i);
  assign quo       = prod / PW'(P_Z0);
  assign floor_val = P_SHIFT_W'(quo);
  assign zx        = P_SHIFT_W'(z_i);
  assign mod_chain[0] = entry_i;

  for (genvar g = 0; g < MOD_STEPS; g++) begin : g_sub
    assign mod_chain[g+1] = (mod_chain[g] >= zx) ? (mod_chain[g] - zx) : mod_chain[g];
  end

  assign pass = entry_i[P_SHIFT_W-1] || (entry_i == '0);

  always_comb begin
    if (pass)                    shift_o = entry_i;
    else if (rule_i == RULE_MOD) shift_o = mod_chain[MOD_STEPS];
    else                         shift_o = floor_val;
  end
endmodule

// File: rtl/ldpc_entry_walker.sv
module ldpc_entry_walker
  import ldpc_scaler_pkg::*;
#(
  parameter int P_ROW_W = ROW_W,
  parameter int P_COL_W = COL_W,
  parameter int P_NCOLS = NCOLS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               launch_i,
  input  logic [P_ROW_W-1:0] rows_i,
  output logic               busy_o,
  output logic [P_ROW_W-1:0] row_o,
  output logic [P_COL_W-1:0] col_o,
  output logic               last_o
);
  localparam logic [P_COL_W-1:0] COL_LAST = P_COL_W'(P_NCOLS - 1);

  logic col_end;

  assign col_end = col_o == COL_LAST;
  assign last_o  = busy_o && col_end && (row_o == rows_i - P_ROW_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_o <= 1'b0;
      row_o  <= '0;
      col_o  <= '0;
    end else if (launch_i) begin
      busy_o <= 1'b1;
      row_o  <= '0;
      col_o  <= '0;
    end else if (busy_o) begin
      if (last_o) begin
        busy_o <= 1'b0;
      end else if (col_end) begin
        col_o <= '0;
        row_o <= row_o + P_ROW_W'(1);
      end else begin
        col_o <= col_o + P_COL_W'(1);
      end
    end
  end
endmodule

// File: rtl/ldpc_shift_scaler.sv
module ldpc_shift_scaler
  import ldpc_scaler_pkg::*;
#(
  parameter int P_LEN_W   = LEN_W,
  parameter int P_RATE_W  = RATE_W,
  parameter int P_ROW_W   = ROW_W,
  parameter int P_COL_W   = COL_W,
  parameter int P_SHIFT_W = SHIFT_W,
  parameter int P_Z_W     = Z_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 start_i,
  input  logic [P_LEN_W-1:0]   len_i,
  input  logic [P_RATE_W-1:0]  rate_i,
  output logic                 entry_valid_o,
  output logic [P_ROW_W-1:0]   entry_row_o,
  output logic [P_COL_W-1:0]   entry_col_o,
  output logic [P_SHIFT_W-1:0] entry_shift_o,
  output logic                 done_o,
  output logic                 error_o
);
  logic                 cfg_ok;
  logic [P_Z_W-1:0]     cfg_z;
  rule_e                cfg_rule;
  logic [P_ROW_W-1:0]   cfg_rows;

  logic [P_Z_W-1:0]     z_q;
  rule_e                rule_q;
  logic [P_ROW_W-1:0]   rows_q;
  logic [P_RATE_W-1:0]  rate_q;

  logic                 busy;
  logic                 start_acc;
  logic                 walk_last;
  logic [P_ROW_W-1:0]   w_row;
  logic [P_COL_W-1:0]   w_col;
  logic [P_SHIFT_W-1:0] rom_entry;
  logic [P_SHIFT_W-1:0] scaled;

  assign start_acc = start_i && !busy;

  ldpc_scaler_cfg #(
    .P_LEN_W (P_LEN_W),
    .P_RATE_W(P_RATE_W),
    .P_ROW_W (P_ROW_W),
    .P_Z_W   (P_Z_W)
  ) u_cfg (
    .len_i (len_i),
    .rate_i(rate_i),
    .ok_o  (cfg_ok),
    .z_o   (cfg_z),
    .rule_o(cfg_rule),
    .rows_o(cfg_rows)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      z_q    <= '0;
      rule_q <= RULE_FLOOR;
      rows_q <= '0;
      rate_q <= '0;
    end else if (start_acc && cfg_ok) begin
      z_q    <= cfg_z;
      rule_q <= cfg_rule;
      rows_q <= cfg_rows;
      rate_q <= rate_i;
    end
  end

  ldpc_entry_walker #(
    .P_ROW_W(P_ROW_W),
    .P_COL_W(P_COL_W)
  ) u_walk (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .launch_i(start_acc && cfg_ok),
    .rows_i  (rows_q),
    .busy_o  (busy),
    .row_o   (w_row),
    .col_o   (w_col),
    .last_o  (walk_last)
  );

  ldpc_model_rom #(
    .P_RATE_W (P_RATE_W),
    .P_ROW_W  (P_ROW_W),
    .P_COL_W  (P_COL_W),
    .P_SHIFT_W(P_SHIFT_W)
  ) u_rom (
    .rate_i (rate_q),
    .row_i  (w_row),
    .col_i  (w_col),
    .entry_o(rom_entry)
  );

  ldpc_shift_scale #(
    .P_SHIFT_W(P_SHIFT_W),
    .P_Z_W    (P_Z_W)
  ) u_scale (
    .entry_i(rom_entry),
    .z_i    (z_q),
    .rule_i (rule_q),
    .shift_o(scaled)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      entry_valid_o <= 1'b0;
      entry_row_o   <= '0;
      entry_col_o   <= '0;
      entry_shift_o <= '0;
      done_o        <= 1'b0;
      error_o       <= 1'b0;
    end else begin
      entry_valid_o <= busy;
      entry_row_o   <= w_row;
      entry_col_o   <= w_col;
      entry_shift_o <= scaled;
      done_o        <= walk_last;
      error_o       <= start_acc && !cfg_ok;
    end
  end
endmodule

// File: rtl/ldpc_shift_scaler_chk.sv
module ldpc_shift_scaler_chk #(
  parameter int P_ROW_W   = 4,
  parameter int P_COL_W   = 5,
  parameter int P_SHIFT_W = 8,
  parameter int P_Z_W     = 7,
  parameter int P_NCOLS   = 24
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 entry_valid_o,
  input logic [P_ROW_W-1:0]   entry_row_o,
  input logic [P_COL_W-1:0]   entry_col_o,
  input logic [P_SHIFT_W-1:0] entry_shift_o,
  input logic                 done_o,
  input logic                 error_o,
  input logic [P_Z_W-1:0]     z_q,
  input logic [P_ROW_W-1:0]   rows_q
);
  localparam logic [P_COL_W-1:0] COL_LAST = P_COL_W'(P_NCOLS - 1);

  assert_done_has_entry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> entry_valid_o);

  assert_quiet_after_done_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !entry_valid_o);

  assert_error_no_entry_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> !entry_valid_o);

  assert_error_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |=> !error_o);

  assert_col_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_o && !done_o && entry_col_o != COL_LAST) |=>
      (entry_valid_o && entry_col_o == $past(entry_col_o) + P_COL_W'(1)
       && entry_row_o == $past(entry_row_o)));

  assert_row_wrap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_o && !done_o && entry_col_o == COL_LAST) |=>
      (entry_valid_o && entry_col_o == '0
       && entry_row_o == $past(entry_row_o) + P_ROW_W'(1)));

  assert_row_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    entry_valid_o |-> entry_row_o < rows_q);

  assert_shift_below_z_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_o && !entry_shift_o[P_SHIFT_W-1]) |-> entry_shift_o < P_SHIFT_W'(z_q));

  assert_negative_is_zero_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (entry_valid_o && entry_shift_o[P_SHIFT_W-1]) |-> (&entry_shift_o));
endmodule

bind ldpc_shift_scaler ldpc_shift_scaler_chk #(
  .P_ROW_W  (P_ROW_W),
  .P_COL_W  (P_COL_W),
  .P_SHIFT_W(P_SHIFT_W),
  .P_Z_W    (P_Z_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .entry_valid_o(entry_valid_o),
  .entry_row_o  (entry_row_o),
  .entry_col_o  (entry_col_o),
  .entry_shift_o(entry_shift_o),
  .done_o       (done_o),
  .error_o      (error_o),
  .z_q          (z_q),
  .rows_q       (rows_q)
);

// File: tb/ldpc_shift_scaler_tb.sv
`timescale 1ns/1ps
module ldpc_shift_scaler_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [11:0] len_i = '0;
  logic [2:0]  rate_i = '0;
  logic        entry_valid_o;
  logic [3:0]  entry_row_o;
  logic [4:0]  entry_col_o;
  logic [7:0]  entry_shift_o;
  logic        done_o;
  logic        error_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2 clk_i = ~clk_i;

  ldpc_shift_scaler u_dut (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .len_i        (len_i),
    .rate_i       (rate_i),
    .entry_valid_o(entry_valid_o),
    .entry_row_o  (entry_row_o),
    .entry_col_o  (entry_col_o),
    .entry_shift_o(entry_shift_o),
    .done_o       (done_o),
    .error_o      (error_o)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // R11 stub table
  function automatic int ref_raw(input int r, input int i, input int j);
    int h;
    h = (7 * i + 13 * j + 5 * r) % 17;
    if (h < 6) return -1;
    if (h == 6) return 0;
    return ((11 * i + 29 * j + 3 * r) % 95) + 1;
  endfunction

  function automatic int ref_rows(input int r);
    if (r == 0) return 12;
    if (r <= 2) return 8;
    return 6;
  endfunction

  task automatic pulse_start(input int len, input int rate);
    @(negedge clk_i);
    start_i = 1'b1;
    len_i   = 12'(len);
    rate_i  = 3'(rate);
    @(negedge clk_i);
    start_i = 1'b0;
  endtask

  // R4 R5 R6 R7 R8 R9 R10 R11
  task automatic run_matrix(input int len, input int rate, input int inject_at);
    int z;
    int rows;
    int bad;
    int seen_pass;
    z    = len / 24;
    rows = ref_rows(rate);
    bad  = 0;
    seen_pass = 0;
    pulse_start(len, rate);
    chk(entry_valid_o == 1'b0 && error_o == 1'b0, "R5", "valid in first cycle after start", int'(entry_valid_o), 0);
    for (int k = 0; k < rows * 24; k++) begin
      int i;
      int j;
      int raw;
      int exp;
      string rq;
      @(negedge clk_i);
      i   = k / 24;
      j   = k % 24;
      raw = ref_raw(rate, i, j);
      if (raw <= 0) begin exp = raw; rq = "R7/R11"; seen_pass++; end
      else if (rate == 1) begin exp = raw % z; rq = "R9/R11"; end
      else begin exp = raw * z / 96; rq = "R8/R11"; end
      if (!entry_valid_o || int'(entry_row_o) != i || int'(entry_col_o) != j) begin
        bad++;
        chk(1'b0, "R4", "entry position (row*24+col)",
            int'(entry_row_o) * 24 + int'(entry_col_o) + (entry_valid_o ? 0 : 10000), k);
      end
      if (int'($signed(entry_shift_o)) != exp) begin
        bad++;
        chk(1'b0, rq, $sformatf("shift r%0d c%0d rate%0d len%0d", i, j, rate, len),
            int'($signed(entry_shift_o)), exp);
      end
      if (done_o != (k == rows * 24 - 1)) begin
        bad++;
        chk(1'b0, "R6", $sformatf("done at entry %0d", k), int'(done_o), int'(k == rows * 24 - 1));
      end
      if (k == inject_at) begin
        start_i = 1'b1;
        len_i   = 12'd576;
        rate_i  = 3'd1;
      end
      if (k == inject_at + 1) start_i = 1'b0;
    end
    chk(bad == 0, inject_at >= 0 ? "R10" : "R4", $sformatf("mismatching entries rate%0d len%0d", rate, len), bad, 0);
    chk(seen_pass > 0, "R7", "pass-through entries seen", seen_pass, 1);
    @(negedge clk_i);
    chk(entry_valid_o == 1'b0 && done_o == 1'b0, "R6", "valid after done", int'(entry_valid_o), 0);
  endtask

  // R2 R3
  task automatic run_bad(input int len, input int rate);
    int stray;
    stray = 0;
    @(negedge clk_i);
    start_i = 1'b1;
    len_i   = 12'(len);
    rate_i  = 3'(rate);
    @(negedge clk_i);
    start_i = 1'b0;
    chk(error_o == 1'b1, "R3", $sformatf("error for len%0d rate%0d", len, rate), int'(error_o), 1);
    chk(entry_valid_o == 1'b0, "R3", "valid with error", int'(entry_valid_o), 0);
    for (int c = 0; c < 30; c++) begin
      @(negedge clk_i);
      if (entry_valid_o || error_o) stray++;
    end
    chk(stray == 0, "R3", "activity after error pulse", stray, 0);
  endtask

  task automatic check_reset();
    repeat (3) @(negedge clk_i);
    chk(!entry_valid_o && !done_o && !error_o, "R1", "outputs in reset",
        int'({entry_valid_o, done_o, error_o}), 0);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    chk(!entry_valid_o && !done_o && !error_o, "R1", "outputs after reset",
        int'({entry_valid_o, done_o, error_o}), 0);
  endtask

  initial begin
    check_reset();
    run_matrix(2304, 0, -1);   // R2 upper bound, floor identity
    run_matrix(576, 1, -1);    // R2 lower bound, R9 mod 24
    run_matrix(2016, 1, -1);   // R9 mod 84
    run_matrix(1440, 2, -1);   // R8 z=60
    run_matrix(960, 3, -1);    // R8 z=40
    run_matrix(1152, 4, 20);   // R10 start during stream
    run_matrix(576, 0, -1);    // R8 z=24
    run_bad(2328, 0);          // R2 above range
    run_bad(552, 2);           // R2 below range
    run_bad(1000, 1);          // R2 not multiple of 24
    run_bad(1152, 5);          // R2 rate code 5
    run_bad(1152, 7);          // R2 rate code 7
    run_matrix(1728, 3, -1);   // R4 recovers after errors
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule